// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block arbitrates among five interrupt request sources and hands one winner at a time to a processor core. The sources are two external pins, two timer overflow flags and one serial-port flag. A master enable and a per-source enable mask filter the requests. A per-source level bit places each request in a high or a low priority group, and inside each group a fixed scan order settles ties.

Each external pin is synchronised and then read in one of two ways: as an active-low level, or as a falling edge that is caught in a sticky flag. The controller offers the chosen request to the core as a level request together with a vector address. When the core acknowledges, the controller records the request's level as in service. In the same cycle it pulses a clear strobe for the sources whose flags the hardware may clear. A return pulse from the core releases the highest level in service. Preemption follows a simple rule: a high-level request may interrupt a low-level handler, and nothing else may interrupt a running handler.

Top module: `intr_ctrl`

## Requirements
- R1: After reset `irq_req_o` is 0, `in_svc_o` is 2'b00 and `flag_clr_o` is 5'b00000.
- R2: While `glb_en_i` is 0 no request is raised, whatever the pending sources.
- R3: A source whose bit in `src_en_i` is 0 never raises a request.
- R4: Source index order is ext0=0, tmr0=1, ext1=2, tmr1=3, ser=4. Among pending requests of the same level, the lowest index wins.
- R5: A pending high-level request (`prio_i` bit = 1) wins over every low-level request, whatever their indices.
- R6: While `irq_req_o` is 1, `irq_vec_o` equals 0x03 + 8 × (winning index): 0x03, 0x0B, 0x13, 0x1B or 0x23.
- R7: With `ext_type_i` bit = 0, an external pin is pending for as long as its synchronised value is low. Such a pin receives no clear strobe.
- R8: With `ext_type_i` bit = 1, a falling edge on the pin sets a flag that stays pending after the pin returns high. Accepting that source clears the flag.
- R9: On an accepted acknowledge, `flag_clr_o` carries a one-cycle one-hot pulse at the winning index for timers and for edge-mode pins. The serial source (bit 4) is never cleared.
- R10: A high-level request is raised while only the low level is in service. A low-level request is not raised while any level is in service. A request is never raised while its own level is in service.
- R11: An accepted acknowledge sets the winner's level bit in `in_svc_o` (bit 1 = high, bit 0 = low).
- R12: A `reti_i` pulse clears the highest set bit of `in_svc_o`. When a return and an accepted acknowledge occur in the same cycle, the return acts on the levels held before that cycle, and the acknowledged level is then set.
- R13: An acknowledge while `irq_req_o` is 0 changes neither `in_svc_o` nor `flag_clr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Master interrupt enable |
| src_en_i | input | 5 | Per-source enable, indexed in scan order |
| prio_i | input | 5 | Per-source level, 1 = high |
| ext_type_i | input | 2 | External pin detection, 1 = falling edge, 0 = low level |
| ext_pin_i | input | 2 | Asynchronous external request pins |
| tmr_flag_i | input | 2 | Timer overflow flags (timer 0, timer 1) |
| ser_flag_i | input | 1 | Serial port request flag |
| irq_ack_i | input | 1 | Core accepts the current request |
| reti_i | input | 1 | Core returns from a handler |
| irq_req_o | output | 1 | Request to the core |
| irq_vec_o | output | 8 | Vector address of the current request |
| flag_clr_o | output | 5 | Clear strobe per source |
| in_svc_o | output | 2 | In-service levels, bit 1 high, bit 0 low |

## Verification
The return and the acknowledge can fall in the same clock cycle. The return then removes an older level while the acknowledge adds a new one. The bench provokes this by accepting a low-level timer, raising a high-level timer, and asserting the acknowledge and the return together in one cycle. The expected outcome is that only the high level remains in service, with the low level released. A second overlap, between the arrival of a fresh pin edge and the clear of that pin's flag, is resolved in favour of the set. The bench judges the ordinary edge path by the flag clearing on acceptance.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_EXT = 2;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int SER_IDX = 4;
  localparam int LVL_LO  = 0;
  localparam int LVL_HI  = 1;
endpackage

// File: rtl/intr_pin_detect.sv
module intr_pin_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              flag_q;
  logic              pin_s;
  logic              fall;

  assign pin_s = sync_q[STAGES-1];
  assign fall  = last_q & ~pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= pin_s;
      if (!edge_mode_i)  flag_q <= 1'b0;
      else if (fall)     flag_q <= 1'b1;  // new edge beats a same-cycle clear
      else if (clr_i)    flag_q <= 1'b0;
    end
  end

  assign pend_o = edge_mode_i ? flag_q : ~pin_s;
endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     prio_i,
  output logic             valid_o,
  output logic             lvl_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    // scan downwards so the lowest index is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && prio_i[i]) begin
        hi_found = 1'b1;
        hi_idx   = IDX_W'(i);
      end
      if (pend_i[i] && !prio_i[i]) begin
        lo_found = 1'b1;
        lo_idx   = IDX_W'(i);
      end
    end
  end

  assign valid_o = hi_found | lo_found;
  assign lvl_o   = hi_found;
  assign idx_o   = hi_found ? hi_idx : lo_idx;
endmodule

// File: rtl/intr_svc_track.sv
module intr_svc_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       lvl_i,
  input  logic       reti_i,
  output logic [1:0] in_svc_o
);
  logic [1:0] svc_q, drop, add;

  always_comb begin
    drop = 2'b00;
    if (reti_i) begin
      if (svc_q[1])      drop = 2'b10;
      else if (svc_q[0]) drop = 2'b01;
    end
    add = 2'b00;
    if (take_i) add[lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= 2'b00;
    else         svc_q <= (svc_q & ~drop) | add;
  end

  assign in_svc_o = svc_q;
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] prio_i,
  input  logic [NUM_EXT-1:0] ext_type_i,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [NUM_EXT-1:0] tmr_flag_i,
  input  logic               ser_flag_i,
  input  logic               irq_ack_i,
  input  logic               reti_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [NUM_SRC-1:0] flag_clr_o,
  output logic [1:0]         in_svc_o
);
  logic [NUM_SRC-1:0] pend, elig, clrable;
  logic               sel_valid, sel_lvl, allowed, take;
  logic [IDX_W-1:0]   sel_idx;

  // ext pins sit on even indices, timers on odd ones
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    intr_pin_detect #(.STAGES(SYNC_STAGES)) u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (ext_pin_i[e]),
      .edge_mode_i(ext_type_i[e]),
      .clr_i      (flag_clr_o[2*e]),
      .pend_o     (pend[2*e])
    );
    assign pend[2*e+1]    = tmr_flag_i[e];
    assign clrable[2*e]   = ext_type_i[e];
    assign clrable[2*e+1] = 1'b1;
  end
  assign pend[SER_IDX]    = ser_flag_i;
  assign clrable[SER_IDX] = 1'b0;

  assign elig = pend & src_en_i & {NUM_SRC{glb_en_i}};

  intr_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend_i (elig),
    .prio_i (prio_i),
    .valid_o(sel_valid),
    .lvl_o  (sel_lvl),
    .idx_o  (sel_idx)
  );

  assign allowed   = sel_lvl ? !in_svc_o[LVL_HI] : (in_svc_o == 2'b00);
  assign irq_req_o = sel_valid & allowed;
  assign take      = irq_req_o & irq_ack_i;
  assign irq_vec_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(sel_idx);

  always_comb begin
    flag_clr_o = '0;
    if (take) flag_clr_o[sel_idx] = clrable[sel_idx];
  end

  intr_svc_track u_svc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .lvl_i   (sel_lvl),
    .reti_i  (reti_i),
    .in_svc_o(in_svc_o)
  );
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic [4:0]       src_en_i,
  input logic [4:0]       prio_i,
  input logic             irq_ack_i,
  input logic             reti_i,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [4:0]       flag_clr_o,
  input logic [1:0]       in_svc_o
);
  logic [VEC_W-1:0] voff;
  logic [2:0]       vidx;
  assign voff = irq_vec_o - VEC_W'(VEC_BASE);
  assign vidx = 3'(voff / VEC_W'(VEC_STEP));

  AST_REQ_NEEDS_GLB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> glb_en_i); // R2
  AST_REQ_SRC_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> src_en_i[vidx]); // R3
  AST_VEC_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (voff % VEC_W'(VEC_STEP) == 0) && (vidx < 3'd5)); // R6
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_o) && !flag_clr_o[4]); // R9
  AST_CLR_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_o != 5'b0) |-> (irq_ack_i && irq_req_o)); // R9
  AST_NESTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && in_svc_o != 2'b00) |-> (prio_i[vidx] && !in_svc_o[1])); // R10
  AST_TAKE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> (in_svc_o != 2'b00)); // R11
  AST_RETI_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(irq_ack_i && irq_req_o) && $countones(in_svc_o) == 1) |=> (in_svc_o == 2'b00)); // R12
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_req_o && !reti_i) |=> $stable(in_svc_o)); // R13
endmodule

bind intr_ctrl intr_ctrl_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .src_en_i(src_en_i),
  .prio_i(prio_i), .irq_ack_i(irq_ack_i), .reti_i(reti_i), .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o), .flag_clr_o(flag_clr_o), .in_svc_o(in_svc_o)
);

// File: tb/intr_ctrl_tb.sv
module intr_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb_en = 1'b0;
  logic [4:0] src_en = '0, prio = '0;
  logic [1:0] ext_type = '0, ext_pin = 2'b11, tmr_flag = '0;
  logic       ser_flag = 1'b0, ack = 1'b0, reti = 1'b0;
  logic       req;
  logic [7:0] vec;
  logic [4:0] clr;
  logic [1:0] svc;
  logic [4:0] clr_seen;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .src_en_i(src_en), .prio_i(prio),
    .ext_type_i(ext_type), .ext_pin_i(ext_pin), .tmr_flag_i(tmr_flag), .ser_flag_i(ser_flag),
    .irq_ack_i(ack), .reti_i(reti), .irq_req_o(req), .irq_vec_o(vec),
    .flag_clr_o(clr), .in_svc_o(svc)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle acknowledge, optionally with a same-cycle return
  task automatic do_ack(bit with_reti);
    ack = 1'b1;
    reti = with_reti;
    #1 clr_seen = clr;
    @(negedge clk);
    ack = 1'b0;
    reti = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req", req, 0);
    chk("R1 svc", svc, 0);
    chk("R1 clr", clr, 0);
  endtask

  task automatic t_enables();
    src_en = 5'b11111;
    tmr_flag = 2'b01;
    idle(2);
    chk("R2 glb off", req, 0);
    glb_en = 1'b1;
    idle(1);
    chk("R2 glb on", req, 1);
    chk("R6 vec tmr0", vec, 8'h0B);
    src_en = 5'b11101;
    idle(1);
    chk("R3 src masked", req, 0);
    src_en = 5'b11111;
    tmr_flag = 2'b00;
    idle(1);
  endtask

  task automatic t_order();
    tmr_flag = 2'b11;
    ser_flag = 1'b1;
    idle(1);
    chk("R4 tmr0 first", vec, 8'h0B);
    tmr_flag = 2'b10;
    idle(1);
    chk("R4 tmr1 next", vec, 8'h1B);
    tmr_flag = 2'b00;
    idle(1);
    chk("R6 vec ser", vec, 8'h23);
    tmr_flag = 2'b01;
    prio = 5'b10000;
    idle(1);
    chk("R5 high ser wins", vec, 8'h23);
    prio = '0;
    tmr_flag = 2'b00;
    ser_flag = 1'b0;
    idle(1);
  endtask

  task automatic t_level();
    ext_type[0] = 1'b0;
    ext_pin[0] = 1'b0;
    idle(3);
    chk("R7 level pending", req, 1);
    chk("R6 vec ext0", vec, 8'h03);
    do_ack(0);
    chk("R7 no clr in level", clr_seen, 0);
    chk("R11 low in svc", svc, 2'b01);
    ext_pin[0] = 1'b1;
    do_reti();
    idle(3);
    chk("R7 released", req, 0);
    chk("R12 svc cleared", svc, 0);
  endtask

  task automatic t_edge();
    ext_type[1] = 1'b1;
    idle(2);
    ext_pin[1] = 1'b0;
    idle(2);
    ext_pin[1] = 1'b1;
    idle(4);
    chk("R8 edge sticky", req, 1);
    chk("R6 vec ext1", vec, 8'h13);
    do_ack(0);
    chk("R9 clr ext1", clr_seen, 5'b00100);
    do_reti();
    idle(2);
    chk("R8 flag cleared", req, 0);
  endtask

  task automatic t_serial();
    ser_flag = 1'b1;
    idle(1);
    do_ack(0);
    chk("R9 ser not cleared", clr_seen, 0);
    chk("R11 ser svc", svc, 2'b01);
    ser_flag = 1'b0;
    do_reti();
    chk("R12 ser release", svc, 0);
  endtask

  task automatic t_preempt();
    tmr_flag = 2'b01;
    idle(1);
    do_ack(0);
    chk("R9 clr tmr0", clr_seen, 5'b00010);
    tmr_flag = 2'b00;
    tmr_flag[1] = 1'b1;
    idle(1);
    chk("R10 low blocked", req, 0);
    prio[3] = 1'b1;
    idle(1);
    chk("R10 high preempts", req, 1);
    do_ack(0);
    chk("R11 both in svc", svc, 2'b11);
    tmr_flag[1] = 1'b0;
    ser_flag = 1'b1;
    prio[4] = 1'b1;
    idle(1);
    chk("R10 same level blocked", req, 0);
    ser_flag = 1'b0;
    prio = '0;
    do_reti();
    chk("R12 high first", svc, 2'b01);
    do_reti();
    chk("R12 then low", svc, 2'b00);
  endtask

  task automatic t_collide();
    tmr_flag = 2'b01;
    idle(1);
    do_ack(0);
    tmr_flag = 2'b10;
    prio[3] = 1'b1;
    idle(1);
    chk("R10 high offered", req, 1);
    do_ack(1);
    chk("R12 ack with reti", svc, 2'b10);
    tmr_flag = 2'b00;
    prio = '0;
    do_reti();
    chk("R12 final release", svc, 2'b00);
  endtask

  task automatic t_spurious();
    idle(1);
    do_ack(0);
    chk("R13 clr idle", clr_seen, 0);
    chk("R13 svc idle", svc, 0);
  endtask

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enables();
    t_order();
    t_level();
    t_edge();
    t_serial();
    t_preempt();
    t_collide();
    t_spurious();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule